// File: doc/BRIEF.md
# Firmware Word Loader

This block lets a host processor push a firmware image, one 32-bit word at a time, into the program RAM of a USB host controller. The host reaches it through a plain register bus with an address, a write strobe with write data, and a read strobe with read data that is returned combinationally in the same cycle. A control/status register opens and closes a load session and carries a self-clearing commit bit. A data register holds the next word. A separate register stores three interrupt enables and drives them out as pins.

Each committed word leaves the block on a valid/ready write port towards the RAM. After the commit bit is set and a programmable latency has passed, the block raises `ram_wr_valid` with a word address and the word. It keeps all three values unchanged until the RAM accepts them with `ram_wr_ready`, so the RAM may apply back-pressure for any number of cycles. The commit bit reads as 1 for as long as the word has not been accepted. When the host later closes the session, the block raises a completion flag, but only after any word still in flight has been written.

Register offsets: control/status at 0x250, data word at 0x258, interrupt enables at 0x224. Control bits: 0 = session enable, 4 = completion flag (read-only), 8 = commit strobe.

Top module: `fwl_top`

## Requirements
- R1: After reset, every register reads 0, `irq_en` is 0 and `ram_wr_valid` is 0.
- R2: The interrupt-enable register at 0x224 stores write-data bits 2:0. It reads them back in bits 2:0, with all other bits 0, and drives them on `irq_en`. Bit 0 is the controller interrupt, bit 1 the power-management event and bit 2 the system-error interrupt.
- R3: A control write that turns bit 0 from 0 to 1 resets the RAM word address to 0 and clears the completion flag (bit 4).
- R4: While bit 0 is 0, writes to the data register at 0x258 are ignored: its read-back value does not change and no RAM write follows.
- R5: A control write with bits 8 and 0 both set, made while the session is enabled and no word is pending, commits the data word. Bit 8 then reads 1 for at least CLR_LAT cycles and returns to 0 in the cycle after the RAM accepts the word.
- R6: While `ram_wr_valid` is 1 and `ram_wr_ready` is 0, the valid signal, the address and the data stay unchanged.
- R7: Each accepted word raises the RAM word address by one, so an image lands at consecutive addresses starting at 0.
- R8: The word reaches the RAM bit-exact: image byte 0 in bits 7:0 up to byte 3 in bits 31:24, with a zero-padded final partial word passed through unchanged.
- R9: A control write that clears bit 0 while no word is pending sets bit 4 within two cycles. Bit 4 is read-only, and while it is 1, bit 0 reads 0.
- R10: If bit 0 is cleared while a word is pending, that RAM write still completes, and bit 4 rises only afterwards. Writes that would set bit 0 again are ignored until the word is accepted.
- R11: A commit request made while the session is disabled, or while a word is already pending, is ignored and causes no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd | input | 1 | Register read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| irq_en | output | 3 | Interrupt enables: controller, power event, system error |
| ram_wr_valid | output | 1 | A word is offered to the program RAM |
| ram_wr_ready | input | 1 | The RAM accepts the offered word |
| ram_wr_addr | output | 10 | Word address of the offered word |
| ram_wr_data | output | 32 | Offered firmware word |

## Verification
The session close and the draining of a pending word can fall in the same window. The bench provokes this by holding `ram_wr_ready` low, committing a word and then clearing the enable bit. It then checks that the completion flag stays 0 while the commit bit still reads 1 and the word is still offered. After ready is released, the word must be written at the expected address before the flag rises. A second overlap, back-pressure toggling every cycle during a multi-word load, is judged on the addresses and data the RAM receives.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam logic [11:0] OFF_IRQ  = 12'h224;
  localparam logic [11:0] OFF_CTRL = 12'h250;
  localparam logic [11:0] OFF_DATA = 12'h258;
  localparam int BIT_EN   = 0;
  localparam int BIT_DONE = 4;
  localparam int BIT_STB  = 8;
  localparam int IRQ_W    = 3;
endpackage

// File: rtl/fwl_regfile.sv
module fwl_regfile
  import fwl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic              rd,
  input  logic              busy,
  input  logic              success,
  output logic [DW-1:0]     rdata,
  output logic              en,
  output logic [IRQ_W-1:0]  irq_en,
  output logic [DW-1:0]     word,
  output logic              start,
  output logic              en_rise,
  output logic              en_fall
);
  logic hit_ctrl, hit_data, hit_irq;
  logic [DW-1:0] data_q;

  assign hit_ctrl = wr && (addr == ADDR_W'(OFF_CTRL));
  assign hit_data = wr && (addr == ADDR_W'(OFF_DATA));
  assign hit_irq  = wr && (addr == ADDR_W'(OFF_IRQ));

  assign en_rise = hit_ctrl && wdata[BIT_EN] && !en && !busy;
  assign en_fall = hit_ctrl && !wdata[BIT_EN] && en;
  assign start   = hit_ctrl && wdata[BIT_STB] && wdata[BIT_EN] && en && !busy;
  assign word    = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      irq_en <= '0;
      data_q <= '0;
    end else begin
      if (en_rise) en <= 1'b1;
      else if (en_fall) en <= 1'b0;
      if (hit_irq) irq_en <= wdata[IRQ_W-1:0];
      if (hit_data && en) data_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == ADDR_W'(OFF_CTRL)) begin
        rdata[BIT_EN]   = en;
        rdata[BIT_DONE] = success;
        rdata[BIT_STB]  = busy;
      end else if (addr == ADDR_W'(OFF_DATA)) begin
        rdata = data_q;
      end else if (addr == ADDR_W'(OFF_IRQ)) begin
        rdata[IRQ_W-1:0] = irq_en;
      end
    end
  end

  // R4
  data_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && !en) |=> $stable(data_q));
  // R2
  irq_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_irq |=> irq_en == $past(wdata[IRQ_W-1:0]));
endmodule

// File: rtl/fwl_commit.sv
module fwl_commit #(
  parameter int DW      = 32,
  parameter int RAM_AW  = 10,
  parameter int CLR_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en_rise,
  input  logic [DW-1:0]     word,
  input  logic              ram_ready,
  output logic              busy,
  output logic              ram_valid,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DW-1:0]     ram_data
);
  localparam int CW = (CLR_LAT < 2) ? 1 : $clog2(CLR_LAT);

  logic [CW-1:0] cnt;
  logic          take;

  assign ram_valid = busy && (cnt == '0);
  assign take      = ram_valid && ram_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      ram_addr <= '0;
      ram_data <= '0;
    end else begin
      if (start) begin
        busy     <= 1'b1;
        cnt      <= CW'(CLR_LAT - 1);
        ram_data <= word;
      end else if (busy && cnt != '0) begin
        cnt <= cnt - CW'(1);
      end else if (take) begin
        busy <= 1'b0;
      end
      if (en_rise) ram_addr <= '0;
      else if (take) ram_addr <= ram_addr + RAM_AW'(1);
    end
  end

  // R6
  ram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_valid && !ram_ready) |=> (ram_valid && $stable(ram_addr) && $stable(ram_data)));
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ram_addr == $past(ram_addr) + RAM_AW'(1));
  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/fwl_done.sv
module fwl_done (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic en_rise,
  input  logic en_fall,
  input  logic busy,
  output logic success
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      success <= 1'b0;
    end else begin
      if (en_rise) begin
        pend    <= 1'b0;
        success <= 1'b0;
      end else if (en_fall) begin
        pend <= 1'b1;
      end else if (pend && !busy) begin
        pend    <= 1'b0;
        success <= 1'b1;
      end
    end
  end

  // R10
  success_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(success) |-> !busy);
  // R9
  success_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    success |-> !en);
endmodule

// File: rtl/fwl_top.sv
module fwl_top
  import fwl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DW      = 32,
  parameter int RAM_AW  = 10,
  parameter int CLR_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic [IRQ_W-1:0]  irq_en,
  output logic              ram_wr_valid,
  input  logic              ram_wr_ready,
  output logic [RAM_AW-1:0] ram_wr_addr,
  output logic [DW-1:0]     ram_wr_data
);
  logic          en, busy, success, start, en_rise, en_fall;
  logic [DW-1:0] word;

  fwl_regfile #(.ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .busy(busy), .success(success), .rdata(bus_rdata), .en(en),
    .irq_en(irq_en), .word(word), .start(start), .en_rise(en_rise), .en_fall(en_fall)
  );

  fwl_commit #(.DW(DW), .RAM_AW(RAM_AW), .CLR_LAT(CLR_LAT)) u_commit (
    .clk(clk), .rst_n(rst_n), .start(start), .en_rise(en_rise), .word(word),
    .ram_ready(ram_wr_ready), .busy(busy), .ram_valid(ram_wr_valid),
    .ram_addr(ram_wr_addr), .ram_data(ram_wr_data)
  );

  fwl_done u_done (
    .clk(clk), .rst_n(rst_n), .en(en), .en_rise(en_rise), .en_fall(en_fall),
    .busy(busy), .success(success)
  );
endmodule

// File: tb/fwl_top_tb.sv
`timescale 1ns/1ps
module fwl_top_tb;
  localparam logic [11:0] A_IRQ = 12'h224, A_CTRL = 12'h250, A_DATA = 12'h258;
  localparam int LAT = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [2:0]  irq_en;
  logic        ram_wr_valid, ram_wr_ready;
  logic [9:0]  ram_wr_addr;
  logic [31:0] ram_wr_data;
  logic        bp_mode = 1'b0, tog = 1'b0, rdy_force = 1'b1;
  logic [31:0] mem [64];
  int          wcount = 0, nerr = 0, nchk = 0;
  bit          finished = 0;

  always #2 clk = ~clk;
  assign ram_wr_ready = bp_mode ? tog : rdy_force;
  always @(negedge clk) tog <= ~tog;
  always @(posedge clk) if (ram_wr_valid && ram_wr_ready) begin
    mem[ram_wr_addr[5:0]] <= ram_wr_data;
    wcount <= wcount + 1;
  end

  fwl_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_en(irq_en), .ram_wr_valid(ram_wr_valid),
    .ram_wr_ready(ram_wr_ready), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic poll_strobe(input string req, output int polls);
    logic [31:0] v;
    polls = 0;
    do begin brd(A_CTRL, v); polls++; end while (v[8] && polls < 1000);
    check(req, 32'(v[8]), 32'd0);
  endtask

  task automatic load_word(input string req, input logic [31:0] w);
    int p;
    bwr(A_DATA, w);
    bwr(A_CTRL, 32'h101);
    poll_strobe(req, p);
  endtask

  task automatic close_and_wait(input string req);
    logic [31:0] v;
    bwr(A_CTRL, 32'h0);
    brd(A_CTRL, v); brd(A_CTRL, v);
    check(req, v & 32'h111, 32'h010);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    brd(A_CTRL, v); check("R1 ctrl", v, 0);
    brd(A_DATA, v); check("R1 data", v, 0);
    brd(A_IRQ, v);  check("R1 irq", v, 0);
    check("R1 valid", 32'(ram_wr_valid), 0);
    bwr(A_CTRL, 32'h10);
    brd(A_CTRL, v); check("R9 done read-only", v, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    bwr(A_IRQ, 32'hFFFF_FFFD);
    brd(A_IRQ, v); check("R2 readback", v, 32'h5);
    check("R2 pins", 32'(irq_en), 32'h5);
    bwr(A_IRQ, 32'h2);
    brd(A_IRQ, v); check("R2 readback2", v, 32'h2);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    int w0 = wcount;
    bwr(A_DATA, 32'hDEAD_BEEF);
    brd(A_DATA, v); check("R4 data ignored", v, 0);
    bwr(A_CTRL, 32'h100);
    repeat (LAT + 4) @(negedge clk);
    check("R11 strobe while disabled", 32'(wcount), 32'(w0));
    brd(A_CTRL, v); check("R11 strobe bit", v, 0);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    int p;
    bwr(A_CTRL, 32'h1);
    bwr(A_DATA, 32'h4433_2211);
    brd(A_DATA, v); check("R4 data while enabled", v, 32'h4433_2211);
    bwr(A_CTRL, 32'h101);
    brd(A_CTRL, v); check("R5 strobe set", v & 32'h101, 32'h101);
    bwr(A_CTRL, 32'h101);
    poll_strobe("R5 strobe clears", p);
    check("R11 second strobe ignored", 32'(wcount), 1);
    check("R8 byte order", mem[0], 32'h4433_2211);
    close_and_wait("R9 success");
  endtask

  task automatic t_image;
    logic [7:0] img [10];
    logic [31:0] w;
    for (int i = 0; i < 10; i++) img[i] = 8'(8'h30 + i * 7);
    bwr(A_CTRL, 32'h1);
    bp_mode = 1'b1;
    for (int i = 0; i < 10; i += 4) begin
      w = '0;
      for (int j = 0; j < 4; j++) if (i + j < 10) w[8*j +: 8] = img[i + j];
      load_word("R6 backpressured word", w);
    end
    bp_mode = 1'b0;
    check("R7 word count", 32'(wcount), 4);
    check("R3 R7 addr0", mem[0], {img[3], img[2], img[1], img[0]});
    check("R7 addr1", mem[1], {img[7], img[6], img[5], img[4]});
    check("R8 padded tail", mem[2], {16'h0, img[9], img[8]});
    close_and_wait("R9 success after image");
  endtask

  task automatic t_drain;
    logic [31:0] v;
    int p;
    bwr(A_CTRL, 32'h1);
    brd(A_CTRL, v); check("R3 success cleared", v & 32'h10, 0);
    rdy_force = 1'b0;
    bwr(A_DATA, 32'hCAFE_0001);
    bwr(A_CTRL, 32'h101);
    repeat (LAT + 3) @(negedge clk);
    bwr(A_CTRL, 32'h0);
    repeat (3) @(negedge clk);
    brd(A_CTRL, v); check("R10 pending, no success", v & 32'h111, 32'h100);
    check("R10 still offered", 32'(ram_wr_valid), 1);
    bwr(A_CTRL, 32'h1);
    brd(A_CTRL, v); check("R10 re-enable ignored", v & 32'h1, 0);
    rdy_force = 1'b1;
    poll_strobe("R10 drain", p);
    brd(A_CTRL, v); brd(A_CTRL, v);
    check("R10 success after drain", v & 32'h111, 32'h010);
    check("R10 word written at addr0", mem[0], 32'hCAFE_0001);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_irq;
    t_ignored;
    t_latency;
    t_image;
    t_drain;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule